// File: doc/BRIEF.md
# Parallel Flash Program/Erase Sequencer

This block sits on the host side of a 32-bit parallel NOR flash array. The array is four byte-wide devices. Each device has its own chip-select and write-enable strobe, and all four share the address bus, the output enable and the reset line. A single request starts one of four operations: a word program, a sector erase, a whole-chip erase, or a hardware reset pulse. The request also carries a mask that picks which of the four byte lanes take part.

For program and erase, the sequencer plays out the unlock command writes that the devices require. Every bus write is timed by write enable. Its low time, high time and overall cycle length are cycle counts, taken from nanosecond minimums and the clock period and rounded up. After the last command write, the block polls the target location. A lane is finished once bit 7 of its byte reads back as the true value rather than its complement. The block then reports success, or it reports an error when a programmable number of reads passes without every selected lane finishing. The reset operation holds the reset line low for the minimum pulse and then waits out the recovery time before it reports completion.

Top module: `flash_seq`

## Requirements
- R1: Out of reset, busy_o, done_o and err_o are low; every chip select, write enable and output enable is high; fl_rst_no is high; fl_dq_oe_o is low.
- R2: With req_op_i = 0 (program), the bus carries four writes in this order: AAh to 5555h, 55h to 2AAAh, A0h to 5555h, then req_data_i to req_addr_i. Each selected lane gets its own byte of the data. A command byte is the same on every lane.
- R3: With req_op_i = 1 (sector erase), the bus carries six writes: AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, then 30h at req_addr_i with its low 16 bits cleared.
- R4: With req_op_i = 2 (chip erase), the first five writes match R3 and the sixth writes 10h to 5555h.
- R5: Each write holds write enable low for exactly ceil(T_WP_PS/CLK_PS) cycles. Address and data stay constant while write enable is low and for the cycle after it. Consecutive write-enable falls are at least ceil(T_WC_PS/CLK_PS) cycles apart. Output enable stays high during any write.
- R6: Only the lanes set in req_lanes_i (bit n = byte n) see chip select and write enable low. Unselected lanes have no effect on completion. A request with an all-zero lane mask is ignored.
- R7: After the last write, the block reads with output enable low for ceil(T_ACC_PS/CLK_PS) cycles and samples at the end of that window. Between reads it spends one idle cycle. It reads req_addr_i for a program, the sector base for a sector erase, and address 0 for a chip erase. A lane matches when bit 7 of its byte equals the expected bit: bit 7 of that lane's data byte for a program, 1 for an erase. A lane that has matched stays matched.
- R8: When every selected lane has matched, done_o pulses for one cycle and busy_o is already low in that cycle. No further read is issued.
- R9: If the lanes have not all matched after max(poll_limit_i, 1) reads, err_o pulses for one cycle instead and no further read is issued.
- R10: With req_op_i = 3 (reset), fl_rst_no is low for ceil(T_RP_PS/CLK_PS) cycles. Then ceil(T_READY_PS/CLK_PS) cycles pass, and then done_o pulses. No write or read happens during this operation.
- R11: A request presented while busy_o is high is ignored.
- R12: done_o and err_o are never high together. busy_o rises in the cycle after a request with a non-zero lane mask is accepted in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, accepted while idle |
| req_op_i | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 reset |
| req_addr_i | input | ADDR_W | Target word address |
| req_data_i | input | 8*N_LANES | Program data, one byte per lane |
| req_lanes_i | input | N_LANES | Byte lanes taking part |
| poll_limit_i | input | POLL_W | Maximum status reads before error |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle success pulse |
| err_o | output | 1 | One-cycle timeout pulse |
| fl_addr_o | output | ADDR_W | Flash address bus |
| fl_dq_o | output | 8*N_LANES | Write data to flash |
| fl_dq_oe_o | output | 1 | Host drives the data bus |
| fl_dq_i | input | 8*N_LANES | Read data from flash |
| fl_cs_no | output | N_LANES | Per-lane chip select, active low |
| fl_we_no | output | N_LANES | Per-lane write enable, active low |
| fl_oe_no | output | 1 | Shared output enable, active low |
| fl_rst_no | output | 1 | Flash reset, active low |

## Verification
The bench builds the block with CLK_PS = 20000 and leaves the nanosecond minimums at their defaults. That gives a 3-cycle write-enable low phase, a 5-cycle write cycle, a 5-cycle read window, a 25-cycle reset pulse and a 1000-cycle recovery. These counts are short enough that every write, every poll read and the full reset operation can be measured edge by edge in a short run. Poll limits from 0 to 10 reach both outcomes and the limit-equals-need boundary. The flash model keeps unselected lanes showing the complement indefinitely, which proves those lanes are ignored.

// File: rtl/flash_seq_pkg.sv
`timescale 1ns/1ps
package flash_seq_pkg;

  typedef enum logic [1:0] {
    OP_PROG   = 2'd0,
    OP_SERASE = 2'd1,
    OP_CERASE = 2'd2,
    OP_RESET  = 2'd3
  } fseq_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_SETUP,
    ST_WR_LOW,
    ST_WR_HIGH,
    ST_RD,
    ST_RD_GAP,
    ST_RST_LOW,
    ST_RST_WAIT
  } fseq_state_e;

  localparam logic [7:0]  CMD_UNLK1 = 8'hAA;
  localparam logic [7:0]  CMD_UNLK2 = 8'h55;
  localparam logic [7:0]  CMD_PROG  = 8'hA0;
  localparam logic [7:0]  CMD_ERASE = 8'h80;
  localparam logic [7:0]  CMD_SECT  = 8'h30;
  localparam logic [7:0]  CMD_CHIP  = 8'h10;
  localparam logic [15:0] ADR_UNLK1 = 16'h5555;
  localparam logic [15:0] ADR_UNLK2 = 16'h2AAA;

  // nanosecond minimum to clock cycles, rounded up, never below one
  function automatic int ps2cyc(input int t_ps, input int clk_ps);
    int c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/fseq_timer.sv
`timescale 1ns/1ps
module fseq_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/fseq_cmd_gen.sv
`timescale 1ns/1ps
module fseq_cmd_gen
  import flash_seq_pkg::*;
#(
  parameter int N_LANES = 4,
  parameter int ADDR_W  = 21,
  parameter int SECT_W  = 5,
  localparam int DATA_W = 8 * N_LANES
) (
  input  fseq_op_e            op_i,
  input  logic [2:0]          step_i,
  input  logic [ADDR_W-1:0]   tgt_addr_i,
  input  logic [DATA_W-1:0]   tgt_data_i,
  output logic [ADDR_W-1:0]   bus_addr_o,
  output logic [DATA_W-1:0]   bus_data_o,
  output logic                last_o,
  output logic [ADDR_W-1:0]   poll_addr_o,
  output logic [N_LANES-1:0]  exp7_o
);
  localparam logic [ADDR_W-1:0] A1 = ADDR_W'(ADR_UNLK1);
  localparam logic [ADDR_W-1:0] A2 = ADDR_W'(ADR_UNLK2);

  logic [ADDR_W-1:0] sect_base;
  assign sect_base = {tgt_addr_i[ADDR_W-1 -: SECT_W], {(ADDR_W-SECT_W){1'b0}}};

  function automatic logic [DATA_W-1:0] rep(input logic [7:0] b);
    return {N_LANES{b}};
  endfunction

  always_comb begin
    bus_addr_o = A1;
    bus_data_o = rep(CMD_UNLK1);
    last_o     = 1'b0;
    case (op_i)
      OP_PROG: begin
        case (step_i)
          3'd0:    begin bus_addr_o = A1; bus_data_o = rep(CMD_UNLK1); end
          3'd1:    begin bus_addr_o = A2; bus_data_o = rep(CMD_UNLK2); end
          3'd2:    begin bus_addr_o = A1; bus_data_o = rep(CMD_PROG);  end
          default: begin bus_addr_o = tgt_addr_i; bus_data_o = tgt_data_i; last_o = 1'b1; end
        endcase
      end
      OP_SERASE, OP_CERASE: begin
        case (step_i)
          3'd0:    begin bus_addr_o = A1; bus_data_o = rep(CMD_UNLK1); end
          3'd1:    begin bus_addr_o = A2; bus_data_o = rep(CMD_UNLK2); end
          3'd2:    begin bus_addr_o = A1; bus_data_o = rep(CMD_ERASE); end
          3'd3:    begin bus_addr_o = A1; bus_data_o = rep(CMD_UNLK1); end
          3'd4:    begin bus_addr_o = A2; bus_data_o = rep(CMD_UNLK2); end
          default: begin
            last_o = 1'b1;
            if (op_i == OP_SERASE) begin
              bus_addr_o = sect_base; bus_data_o = rep(CMD_SECT);
            end else begin
              bus_addr_o = A1;        bus_data_o = rep(CMD_CHIP);
            end
          end
        endcase
      end
      default: last_o = 1'b1;
    endcase
  end

  always_comb begin
    case (op_i)
      OP_PROG:   poll_addr_o = tgt_addr_i;
      OP_SERASE: poll_addr_o = sect_base;
      default:   poll_addr_o = '0;
    endcase
  end

  // erased cells read back as ones
  for (genvar l = 0; l < N_LANES; l++) begin : g_exp
    assign exp7_o[l] = (op_i == OP_PROG) ? tgt_data_i[8*l+7] : 1'b1;
  end
endmodule

// File: rtl/fseq_lane_poll.sv
`timescale 1ns/1ps
module fseq_lane_poll #(
  parameter int N_LANES = 4,
  localparam int DATA_W = 8 * N_LANES
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               sample_i,
  input  logic [N_LANES-1:0] lanes_i,
  input  logic [N_LANES-1:0] exp7_i,
  input  logic [DATA_W-1:0]  dq_i,
  output logic               all_o
);
  logic [N_LANES-1:0] hit, seen_q;

  for (genvar l = 0; l < N_LANES; l++) begin : g_lane
    assign hit[l] = (dq_i[8*l+7] == exp7_i[l]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                seen_q[l] <= 1'b0;
      else if (clr_i)             seen_q[l] <= 1'b0;
      else if (sample_i && hit[l]) seen_q[l] <= 1'b1;
    end
  end

  // counts the read being sampled now
  assign all_o = &(seen_q | hit | ~lanes_i);
endmodule

// File: rtl/flash_seq.sv
`timescale 1ns/1ps
module flash_seq
  import flash_seq_pkg::*;
#(
  parameter int N_LANES    = 4,
  parameter int ADDR_W     = 21,
  parameter int SECT_W     = 5,
  parameter int POLL_W     = 16,
  parameter int CLK_PS     = 5000,
  parameter int T_WP_PS    = 45000,
  parameter int T_WPH_PS   = 20000,
  parameter int T_WC_PS    = 90000,
  parameter int T_ACC_PS   = 90000,
  parameter int T_RP_PS    = 500000,
  parameter int T_READY_PS = 20000000,
  localparam int DATA_W    = 8 * N_LANES
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [1:0]         req_op_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [DATA_W-1:0]  req_data_i,
  input  logic [N_LANES-1:0] req_lanes_i,
  input  logic [POLL_W-1:0]  poll_limit_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               err_o,
  output logic [ADDR_W-1:0]  fl_addr_o,
  output logic [DATA_W-1:0]  fl_dq_o,
  output logic               fl_dq_oe_o,
  input  logic [DATA_W-1:0]  fl_dq_i,
  output logic [N_LANES-1:0] fl_cs_no,
  output logic [N_LANES-1:0] fl_we_no,
  output logic               fl_oe_no,
  output logic               fl_rst_no
);
  localparam int WP_CYC    = ps2cyc(T_WP_PS, CLK_PS);
  localparam int WPH_CYC   = ps2cyc(T_WPH_PS, CLK_PS);
  localparam int WC_CYC    = ps2cyc(T_WC_PS, CLK_PS);
  localparam int ACC_CYC   = ps2cyc(T_ACC_PS, CLK_PS);
  localparam int RP_CYC    = ps2cyc(T_RP_PS, CLK_PS);
  localparam int READY_CYC = ps2cyc(T_READY_PS, CLK_PS);
  // one setup cycle + low phase + high phase must cover the write cycle
  localparam int HI_CYC    = (WC_CYC - WP_CYC - 1 > WPH_CYC) ? WC_CYC - WP_CYC - 1 : WPH_CYC;
  localparam int TMR_W     = $clog2(RP_CYC + READY_CYC + WC_CYC + ACC_CYC + 2);

  fseq_state_e         state_q, state_d;
  fseq_op_e            op_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   data_q;
  logic [N_LANES-1:0]  lanes_q;
  logic [POLL_W-1:0]   limit_q, polls_q, lim_eff;
  logic [2:0]          step_q;
  logic                done_q, err_q;

  logic                tmr_load, tmr_zero;
  logic [TMR_W-1:0]    tmr_val;
  logic                start, step_inc, poll_clr, poll_smp, poll_inc, fin_ok, fin_err;
  logic                last_try, all_hit, cmd_last;
  logic [ADDR_W-1:0]   cmd_addr, poll_addr;
  logic [DATA_W-1:0]   cmd_data;
  logic [N_LANES-1:0]  exp7;

  fseq_timer #(.W(TMR_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  fseq_cmd_gen #(.N_LANES(N_LANES), .ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_cmd (
    .op_i        (op_q),
    .step_i      (step_q),
    .tgt_addr_i  (addr_q),
    .tgt_data_i  (data_q),
    .bus_addr_o  (cmd_addr),
    .bus_data_o  (cmd_data),
    .last_o      (cmd_last),
    .poll_addr_o (poll_addr),
    .exp7_o      (exp7)
  );

  fseq_lane_poll #(.N_LANES(N_LANES)) u_poll (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (poll_clr),
    .sample_i (poll_smp),
    .lanes_i  (lanes_q),
    .exp7_i   (exp7),
    .dq_i     (fl_dq_i),
    .all_o    (all_hit)
  );

  assign lim_eff  = (limit_q == '0) ? POLL_W'(1) : limit_q;
  assign last_try = ({1'b0, polls_q} + 1'b1) >= {1'b0, lim_eff};

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    start    = 1'b0;
    step_inc = 1'b0;
    poll_clr = 1'b0;
    poll_smp = 1'b0;
    poll_inc = 1'b0;
    fin_ok   = 1'b0;
    fin_err  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid_i && (|req_lanes_i)) begin
          start = 1'b1;
          if (fseq_op_e'(req_op_i) == OP_RESET) begin
            state_d  = ST_RST_LOW;
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(RP_CYC - 1);
          end else begin
            state_d = ST_WR_SETUP;
          end
        end
      end
      ST_WR_SETUP: begin
        state_d  = ST_WR_LOW;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(WP_CYC - 1);
      end
      ST_WR_LOW: if (tmr_zero) begin
        state_d  = ST_WR_HIGH;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(HI_CYC - 1);
      end
      ST_WR_HIGH: if (tmr_zero) begin
        if (cmd_last) begin
          state_d  = ST_RD;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(ACC_CYC - 1);
          poll_clr = 1'b1;
        end else begin
          state_d  = ST_WR_SETUP;
          step_inc = 1'b1;
        end
      end
      ST_RD: if (tmr_zero) begin
        poll_smp = 1'b1;
        if (all_hit) begin
          state_d = ST_IDLE;
          fin_ok  = 1'b1;
        end else if (last_try) begin
          state_d = ST_IDLE;
          fin_err = 1'b1;
        end else begin
          state_d  = ST_RD_GAP;
          poll_inc = 1'b1;
        end
      end
      ST_RD_GAP: begin
        state_d  = ST_RD;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(ACC_CYC - 1);
      end
      ST_RST_LOW: if (tmr_zero) begin
        state_d  = ST_RST_WAIT;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(READY_CYC - 1);
      end
      ST_RST_WAIT: if (tmr_zero) begin
        state_d = ST_IDLE;
        fin_ok  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= OP_PROG;
      addr_q  <= '0;
      data_q  <= '0;
      lanes_q <= '0;
      limit_q <= '0;
      step_q  <= '0;
      polls_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= fin_ok;
      err_q   <= fin_err;
      if (start) begin
        op_q    <= fseq_op_e'(req_op_i);
        addr_q  <= req_addr_i;
        data_q  <= req_data_i;
        lanes_q <= req_lanes_i;
        limit_q <= poll_limit_i;
        step_q  <= '0;
      end else if (step_inc) begin
        step_q <= step_q + 1'b1;
      end
      if (poll_clr)      polls_q <= '0;
      else if (poll_inc) polls_q <= polls_q + 1'b1;
    end
  end

  logic in_wr, in_rd;
  assign in_wr = (state_q == ST_WR_SETUP) || (state_q == ST_WR_LOW) || (state_q == ST_WR_HIGH);
  assign in_rd = (state_q == ST_RD);

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign fl_cs_no   = (in_wr || in_rd) ? ~lanes_q : '1;
  assign fl_we_no   = (state_q == ST_WR_LOW) ? ~lanes_q : '1;
  assign fl_oe_no   = ~in_rd;
  assign fl_dq_oe_o = in_wr;
  assign fl_addr_o  = in_wr ? cmd_addr : (in_rd ? poll_addr : '0);
  assign fl_dq_o    = in_wr ? cmd_data : '0;
  assign fl_rst_no  = (state_q != ST_RST_LOW);
endmodule

// File: rtl/fseq_checker.sv
`timescale 1ns/1ps
module fseq_checker #(
  parameter int N_LANES = 4,
  parameter int ADDR_W  = 21,
  parameter int WP_CYC  = 9,
  localparam int DATA_W = 8 * N_LANES
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic [N_LANES-1:0] req_lanes_i,
  input logic               busy_o,
  input logic               done_o,
  input logic               err_o,
  input logic [ADDR_W-1:0]  fl_addr_o,
  input logic [DATA_W-1:0]  fl_dq_o,
  input logic               fl_dq_oe_o,
  input logic [N_LANES-1:0] fl_cs_no,
  input logic [N_LANES-1:0] fl_we_no,
  input logic               fl_oe_no,
  input logic               fl_rst_no
);
  logic [15:0] we_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       we_cnt <= '0;
    else if (&fl_we_no) we_cnt <= '0;
    else               we_cnt <= we_cnt + 1'b1;
  end

  p_quiet_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> ((&fl_we_no) && (&fl_cs_no) && fl_oe_no && fl_rst_no && !fl_dq_oe_o));

  p_we_width_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&fl_we_no) && (we_cnt != 16'd0)) |-> (we_cnt == 16'(WP_CYC)));

  p_we_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&fl_we_no) |=> ($stable(fl_addr_o) && $stable(fl_dq_o)));

  p_we_no_oe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&fl_we_no) |-> (fl_oe_no && fl_dq_oe_o));

  p_we_in_cs_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~fl_we_no) & fl_cs_no) == '0);

  p_read_no_drive_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fl_oe_no |-> !fl_dq_oe_o);

  p_finish_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || err_o) |-> (!busy_o && $past(busy_o)));

  p_rst_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fl_rst_no |-> (busy_o && (&fl_we_no) && fl_oe_no));

  p_excl_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));

  p_accept_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_valid_i && (|req_lanes_i)) |=> busy_o);
endmodule

bind flash_seq fseq_checker #(
  .N_LANES (N_LANES),
  .ADDR_W  (ADDR_W),
  .WP_CYC  (WP_CYC)
) u_fseq_chk (.*);

// File: tb/flash_seq_bench.sv
`timescale 1ns/1ps
module flash_seq_bench;
  localparam int CYC_WP = 3, CYC_WC = 5, CYC_RP = 25, CYC_READY = 1000;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [1:0]  req_op_i = '0;
  logic [20:0] req_addr_i = '0;
  logic [31:0] req_data_i = '0;
  logic [3:0]  req_lanes_i = '0;
  logic [15:0] poll_limit_i = '0;
  logic        busy_o, done_o, err_o, fl_dq_oe_o, fl_oe_no, fl_rst_no;
  logic [20:0] fl_addr_o;
  logic [31:0] fl_dq_o, fl_dq_i;
  logic [3:0]  fl_cs_no, fl_we_no;

  always #2.5 clk_i = ~clk_i;

  flash_seq #(.CLK_PS(20000)) u_flash_seq (.*);

  int n_chk = 0, n_fail = 0, cyc = 0;
  int rem [4];
  logic [7:0] tru [4];
  logic [20:0] qa [$];
  logic [31:0] qd [$];
  logic [3:0]  exp_lanes = '0;
  logic [20:0] exp_poll = '0;
  int got_done, got_err, reads, busy_cyc, rst_low, wr_in_op, low_cnt, last_fall, writes_total;
  logic [3:0] we_prev = '0;
  logic oe_prev = 1'b1;

  task automatic chk(input bit ok, input string rq, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // flash model: a busy lane shows the complement of bit 7
  always_comb
    for (int l = 0; l < 4; l++) begin
      fl_dq_i[8*l +: 8] = tru[l];
      if (rem[l] > 0) fl_dq_i[8*l+7] = ~tru[l][7];
    end

  always @(negedge clk_i) begin
    if (rst_ni) begin
      cyc++;
      if (done_o) got_done++;
      if (err_o) got_err++;
      if (busy_o) busy_cyc++;
      if (!fl_rst_no) rst_low++;
      if (|(~fl_we_no)) begin
        if (we_prev == '0) begin
          if (wr_in_op > 0) chk(cyc - last_fall >= CYC_WC, "R5", "write spacing", cyc - last_fall, CYC_WC);
          last_fall = cyc;
        end
        low_cnt++;
      end else if (we_prev != '0) begin
        logic [31:0] m;
        m = {{8{exp_lanes[3]}}, {8{exp_lanes[2]}}, {8{exp_lanes[1]}}, {8{exp_lanes[0]}}};
        chk(low_cnt == CYC_WP, "R5", "we low width", low_cnt, CYC_WP);
        chk(we_prev == exp_lanes, "R6", "we lanes", we_prev, exp_lanes);
        if (qa.size() == 0) chk(0, "R11", "unexpected write", fl_addr_o, 0);
        else begin
          logic [20:0] ea; logic [31:0] ed;
          ea = qa.pop_front(); ed = qd.pop_front();
          chk(fl_addr_o == ea, "R2/R3/R4", "write addr", fl_addr_o, ea);
          chk((fl_dq_o & m) == (ed & m), "R2/R3/R4", "write data", fl_dq_o & m, ed & m);
        end
        low_cnt = 0; wr_in_op++; writes_total++;
      end
      we_prev = ~fl_we_no;
      if (!fl_oe_no && oe_prev) begin
        reads++;
        chk(fl_addr_o == exp_poll, "R7", "poll addr", fl_addr_o, exp_poll);
      end
      if (fl_oe_no && !oe_prev)
        for (int l = 0; l < 4; l++) if (rem[l] > 0) rem[l]--;
      oe_prev = fl_oe_no;
      if (cyc > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected < 150000 cycles", cyc);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
      end
    end
  end

  function automatic logic [31:0] rep(input logic [7:0] b);
    return {4{b}};
  endfunction

  task automatic run_op(input int op, input logic [20:0] a, input logic [31:0] d, input logic [3:0] ln,
                        input int lim, input int p0, input int p1, input int p2, input int p3,
                        input bit poke, input string tag);
    int p [4];
    int need, lim_eff, exp_reads;
    bit exp_err;
    p[0] = p0; p[1] = p1; p[2] = p2; p[3] = p3;
    need = 0;
    for (int l = 0; l < 4; l++) begin
      tru[l] = (op == 0) ? d[8*l +: 8] : 8'hFF;
      rem[l] = p[l];
      if (ln[l] && p[l] + 1 > need) need = p[l] + 1;
    end
    lim_eff = (lim == 0) ? 1 : lim;
    exp_err = (op != 3) && (need > lim_eff);
    exp_reads = (op == 3) ? 0 : (exp_err ? lim_eff : need);
    if (op != 3) begin
      qa.push_back(21'h05555); qd.push_back(rep(8'hAA));
      qa.push_back(21'h02AAA); qd.push_back(rep(8'h55));
      if (op == 0) begin
        qa.push_back(21'h05555); qd.push_back(rep(8'hA0));
        qa.push_back(a);         qd.push_back(d);
      end else begin
        qa.push_back(21'h05555); qd.push_back(rep(8'h80));
        qa.push_back(21'h05555); qd.push_back(rep(8'hAA));
        qa.push_back(21'h02AAA); qd.push_back(rep(8'h55));
        if (op == 1) begin qa.push_back(a & 21'h1F0000); qd.push_back(rep(8'h30)); end
        else         begin qa.push_back(21'h05555);      qd.push_back(rep(8'h10)); end
      end
    end
    exp_poll  = (op == 0) ? a : (op == 1) ? (a & 21'h1F0000) : 21'h0;
    exp_lanes = ln;
    got_done = 0; got_err = 0; reads = 0; busy_cyc = 0; rst_low = 0; wr_in_op = 0;
    @(negedge clk_i);
    req_valid_i = 1'b1; req_op_i = 2'(op); req_addr_i = a; req_data_i = d;
    req_lanes_i = ln; poll_limit_i = 16'(lim);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(busy_o == 1'b1, "R12", {tag, " busy after accept"}, busy_o, 1);
    if (poke) begin
      repeat (4) @(negedge clk_i);
      req_valid_i = 1'b1; req_op_i = 2'd2; req_lanes_i = 4'hF;
      @(negedge clk_i);
      req_valid_i = 1'b0;
    end
    for (int i = 0; i < 5000 && (got_done + got_err) == 0; i++) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
    chk(got_done == (exp_err ? 0 : 1), exp_err ? "R9" : "R8", {tag, " done pulses"}, got_done, exp_err ? 0 : 1);
    chk(got_err == (exp_err ? 1 : 0), exp_err ? "R9" : "R8", {tag, " err pulses"}, got_err, exp_err ? 1 : 0);
    chk(reads == exp_reads, exp_err ? "R9" : "R7", {tag, " read count"}, reads, exp_reads);
    chk(qa.size() == 0, tag, "writes missing", qa.size(), 0);
    chk(busy_o == 1'b0, "R8", {tag, " busy after end"}, busy_o, 0);
    if (op == 3) begin
      chk(rst_low == CYC_RP, "R10", "reset low cycles", rst_low, CYC_RP);
      chk(busy_cyc == CYC_RP + CYC_READY, "R10", "reset busy cycles", busy_cyc, CYC_RP + CYC_READY);
      chk(wr_in_op == 0, "R10", "writes during reset", wr_in_op, 0);
    end
    qa.delete(); qd.delete();
  endtask

  initial begin
    for (int l = 0; l < 4; l++) begin rem[l] = 0; tru[l] = 8'h00; end
    writes_total = 0; low_cnt = 0; last_fall = 0;
    repeat (3) @(negedge clk_i);
    chk(busy_o == 0 && done_o == 0 && err_o == 0, "R1", "status at reset", {busy_o, done_o, err_o}, 0);
    chk(fl_cs_no == 4'hF && fl_we_no == 4'hF && fl_oe_no && fl_rst_no && !fl_dq_oe_o, "R1", "bus at reset",
        {fl_cs_no, fl_we_no, fl_oe_no, fl_rst_no, fl_dq_oe_o}, 11'h7FE);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(busy_o == 0 && fl_we_no == 4'hF, "R1", "idle after reset", {busy_o, fl_we_no}, 5'h0F);

    run_op(0, 21'h12345, 32'h80_7F_FF_01, 4'hF, 10, 2, 0, 1, 3, 0, "R2 program all lanes");
    run_op(0, 21'h1ABCDE, 32'hC3_5A_A5_3C, 4'b0101, 4, 1, 99, 0, 99, 0, "R6 program two lanes");
    run_op(1, 21'h0B1234, 32'h0, 4'hF, 8, 3, 3, 3, 3, 0, "R3 sector erase");
    run_op(2, 21'h1F0F0F, 32'h0, 4'b1000, 6, 0, 0, 0, 5, 0, "R4 chip erase at limit");
    run_op(0, 21'h00042, 32'h11_22_33_44, 4'hF, 5, 0, 7, 0, 0, 0, "R9 timeout");
    run_op(0, 21'h00077, 32'hFF_00_FF_00, 4'hF, 0, 1, 0, 0, 0, 0, "R9 zero limit");
    run_op(0, 21'h0ABCD, 32'h01_02_03_04, 4'hF, 10, 1, 1, 1, 1, 1, "R11 request while busy");

    begin : zero_lanes
      int w0;
      w0 = writes_total;
      @(negedge clk_i);
      req_valid_i = 1'b1; req_op_i = 2'd0; req_lanes_i = 4'h0;
      @(negedge clk_i);
      req_valid_i = 1'b0;
      repeat (8) @(negedge clk_i);
      chk(busy_o == 0, "R6", "zero-lane request busy", busy_o, 0);
      chk(writes_total == w0, "R6", "zero-lane request writes", writes_total - w0, 0);
    end

    run_op(3, 21'h0, 32'h0, 4'hF, 1, 0, 0, 0, 0, 0, "R10 reset op");

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule